// File: doc/BRIEF.md
# Emulated Entropy Pool

This block stands in for a hardware random source on chips where a real noise source is not available. A 32-bit linear feedback shift register produces one pseudo-random bit at a fixed cadence while generation is enabled. The bits collect in a bounded pool, and software sees how many bits are waiting and takes them out one 32-bit word at a time through a small register port.

A word read made when fewer than 32 bits are waiting is treated as an error. The read returns zero and takes nothing from the pool. It sets a sticky underflow flag that drives a level interrupt, and it produces a one-cycle alert pulse. Turning generation off also discards everything that is in the pool.

Register map on the 2-bit address:
- 0 is control, with the enable in bit 0.
- 1 is the available-bit count, zero-extended.
- 2 is the data word.
- 3 is status, with the underflow flag in bit 0.

Top module: `entropy_pool`

## Requirements
- R1: After reset, generation is off, the count is 0, the underflow flag is clear, and both the interrupt and the alert are low.
- R2: While enabled and not full, exactly one bit enters the pool every TICK_DIV cycles. The generator state s advances as s' = {s[30:0], s[31]^s[21]^s[1]^s[0]} from the seed SEED, and the new low bit is the bit that enters the pool.
- R3: The count never exceeds POOL_BITS. While the pool is full, generation halts and no generator output is lost. After a read frees space, the first new bit arrives TICK_DIV cycles later.
- R4: A data read (address 2) made while the count is at least 32 returns the 32 oldest bits, with the oldest bit in bit 31. It lowers the count by 32.
- R5: A data read made while the count is below 32 returns 0 and removes no bits, and it sets the underflow flag (status bit 0).
- R6: A failed data read produces a one-cycle alert pulse in the cycle after the request. Successful reads and all other accesses leave the alert low.
- R7: The interrupt follows the underflow flag. Writing status with bit 0 set clears the flag, and writing it with bit 0 clear has no effect.
- R8: Writing control with bit 0 clear empties the pool, so the count becomes 0. No bits are generated while generation is off.
- R9: Read data appears on regRdata one cycle after the request and holds until the next read. Writes to the count and data addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regReq | input | 1 | Register access strobe, one access per cycle |
| regWe | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | 2 | 0 control, 1 count, 2 data, 3 status |
| regWdata | input | 32 | Write data, of which only bit 0 is used |
| regRdata | output | 32 | Registered read data |
| irqUnderflow | output | 1 | Level interrupt equal to the sticky underflow flag |
| alertUnderflow | output | 1 | One-cycle pulse per failed data read |

## Verification
The bench builds the block with a 64-bit pool and a 3-cycle generation period. At these settings the pool fills in about 200 cycles, so many fill, drain and flush rounds fit in a short run. A bench-side copy of the generator recurrence predicts every word across all of these rounds. Because the refill restarts after a fixed 3-cycle period, the count is exact right after a drain. That makes the 32-bit boundary reachable: a read at exactly 32 bits succeeds, and the read right after it fails with an empty pool.

// File: rtl/entropy_pool_pkg.sv
package entropy_pool_pkg;

  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_DATA   = 2'd2,
    ADDR_STATUS = 2'd3
  } regAddr_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic addBit;   // shift one new generator bit into the pool
    logic consume;  // remove the oldest word
    logic flush;    // discard the whole pool
  } poolStrobe_t;

  // one step of the maximal-length recurrence, taps 32,22,2,1
  function automatic logic [31:0] lfsrStep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/entropy_pool_datapath.sv
module entropy_pool_datapath
  import entropy_pool_pkg::*;
#(
  parameter int          POOL_BITS = 128,
  parameter logic [31:0] SEED      = 32'h5EED_1234,
  parameter int          CNT_W     = $clog2(POOL_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  poolStrobe_t       strobe,
  output logic [CNT_W-1:0]  poolCount,
  output logic              wordReady,
  output logic              poolFull,
  output logic [WORD_BITS-1:0] oldestWord
);

  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(POOL_BITS);

  logic [31:0]          lfsrState;
  logic [31:0]          lfsrNext;
  logic [POOL_BITS-1:0] poolBits;
  logic [CNT_W-1:0]     countNext;
  logic [CNT_W-1:0]     shiftAmt;

  assign lfsrNext = lfsrStep(lfsrState);

  always_comb begin
    countNext = poolCount;
    if (strobe.flush) begin
      countNext = '0;
    end else begin
      if (strobe.addBit)  countNext = countNext + CNT_W'(1);
      if (strobe.consume) countNext = countNext - WORD_CNT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrState <= SEED;
      poolBits  <= '0;
      poolCount <= '0;
    end else begin
      if (strobe.addBit && !strobe.flush) begin
        lfsrState <= lfsrNext;
        poolBits  <= {poolBits[POOL_BITS-2:0], lfsrNext[0]};
      end
      poolCount <= countNext;
    end
  end

  // newest bit sits at index 0, oldest at poolCount-1
  assign shiftAmt   = poolCount - WORD_CNT;
  assign oldestWord = WORD_BITS'(poolBits >> shiftAmt);
  assign wordReady  = (poolCount >= WORD_CNT);
  assign poolFull   = (poolCount == FULL_CNT);

endmodule

// File: rtl/entropy_pool_ctrl.sv
module entropy_pool_ctrl
  import entropy_pool_pkg::*;
#(
  parameter int POOL_BITS = 128,
  parameter int TICK_DIV  = 4,
  parameter int CNT_W     = $clog2(POOL_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regReq,
  input  logic                 regWe,
  input  logic [1:0]           regAddr,
  input  logic                 wdataBit,
  input  logic [CNT_W-1:0]     poolCount,
  input  logic                 wordReady,
  input  logic                 poolFull,
  input  logic [WORD_BITS-1:0] oldestWord,
  output poolStrobe_t          strobe,
  output logic [31:0]          regRdata,
  output logic                 irqUnderflow,
  output logic                 alertUnderflow
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  regAddr_e        addrSel;
  logic            genEnable;
  logic            underflowFlag;
  logic [DIV_W-1:0] divCnt;
  logic            divLast;
  logic            isRead;
  logic            dataRead;
  logic            readFail;
  logic            ctrlWrite;
  logic            statusClear;

  assign addrSel     = regAddr_e'(regAddr);
  assign isRead      = regReq && !regWe;
  assign dataRead    = isRead && (addrSel == ADDR_DATA);
  assign readFail    = dataRead && !wordReady;
  assign ctrlWrite   = regReq && regWe && (addrSel == ADDR_CTRL);
  assign statusClear = regReq && regWe && (addrSel == ADDR_STATUS) && wdataBit;
  assign divLast     = (divCnt == DIV_LAST);

  always_comb begin
    strobe.flush   = ctrlWrite && !wdataBit;
    strobe.consume = dataRead && wordReady;
    strobe.addBit  = genEnable && !poolFull && divLast && !strobe.flush;
  end

  // cadence counter runs only while a bit could be accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!genEnable || poolFull || strobe.flush) begin
      divCnt <= '0;
    end else if (divLast) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genEnable      <= 1'b0;
      underflowFlag  <= 1'b0;
      alertUnderflow <= 1'b0;
    end else begin
      if (ctrlWrite) genEnable <= wdataBit;
      if (readFail) underflowFlag <= 1'b1;
      else if (statusClear) underflowFlag <= 1'b0;
      alertUnderflow <= readFail;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (isRead) begin
      unique case (addrSel)
        ADDR_CTRL:   regRdata <= {31'b0, genEnable};
        ADDR_COUNT:  regRdata <= 32'(poolCount);
        ADDR_DATA:   regRdata <= wordReady ? oldestWord : 32'b0;
        ADDR_STATUS: regRdata <= {31'b0, underflowFlag};
        default:     regRdata <= '0;
      endcase
    end
  end

  assign irqUnderflow = underflowFlag;

endmodule

// File: rtl/entropy_pool.sv
module entropy_pool
  import entropy_pool_pkg::*;
#(
  parameter int          POOL_BITS = 128,
  parameter int          TICK_DIV  = 4,
  parameter logic [31:0] SEED      = 32'h5EED_1234
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regReq,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irqUnderflow,
  output logic        alertUnderflow
);

  localparam int CNT_W = $clog2(POOL_BITS + 1);

  poolStrobe_t          strobe;
  logic [CNT_W-1:0]     poolCount;
  logic                 wordReady;
  logic                 poolFull;
  logic [WORD_BITS-1:0] oldestWord;
  logic                 unusedWdataBits;

  assign unusedWdataBits = ^regWdata[31:1];

  entropy_pool_ctrl #(
    .POOL_BITS(POOL_BITS),
    .TICK_DIV (TICK_DIV),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .regReq        (regReq),
    .regWe         (regWe),
    .regAddr       (regAddr),
    .wdataBit      (regWdata[0]),
    .poolCount     (poolCount),
    .wordReady     (wordReady),
    .poolFull      (poolFull),
    .oldestWord    (oldestWord),
    .strobe        (strobe),
    .regRdata      (regRdata),
    .irqUnderflow  (irqUnderflow),
    .alertUnderflow(alertUnderflow)
  );

  entropy_pool_datapath #(
    .POOL_BITS(POOL_BITS),
    .SEED     (SEED),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .poolCount (poolCount),
    .wordReady (wordReady),
    .poolFull  (poolFull),
    .oldestWord(oldestWord)
  );

endmodule

// File: rtl/entropy_pool_chk.sv
module entropy_pool_chk #(
  parameter int POOL_BITS = 128,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regReq,
  input logic             regWe,
  input logic [1:0]       regAddr,
  input logic             wdataLsb,
  input logic             irqUnderflow,
  input logic             alertUnderflow,
  input logic [CNT_W-1:0] poolCount
);

  logic dataRd, rdOk, rdBad, ctrlOff, statClr;
  int   cnt;

  assign cnt     = int'(poolCount);
  assign dataRd  = regReq && !regWe && (regAddr == 2'd2);
  assign rdOk    = dataRd && (cnt >= 32);
  assign rdBad   = dataRd && (cnt < 32);
  assign ctrlOff = regReq && regWe && (regAddr == 2'd0) && !wdataLsb;
  assign statClr = regReq && regWe && (regAddr == 2'd3) && wdataLsb;

  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= POOL_BITS);

  p_gen_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!dataRd && !ctrlOff) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1));

  p_consume_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdOk |=> (cnt == $past(cnt) - 32 || cnt == $past(cnt) - 31));

  p_fail_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdBad |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1));

  p_alert_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdBad |=> alertUnderflow);

  p_alert_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdBad |=> !alertUnderflow);

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdBad |=> irqUnderflow);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqUnderflow && !statClr) |=> irqUnderflow);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOff |=> (cnt == 0));

endmodule

bind entropy_pool entropy_pool_chk #(
  .POOL_BITS(POOL_BITS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regReq        (regReq),
  .regWe         (regWe),
  .regAddr       (regAddr),
  .wdataLsb      (regWdata[0]),
  .irqUnderflow  (irqUnderflow),
  .alertUnderflow(alertUnderflow),
  .poolCount     (poolCount)
);

// File: tb/tb_entropy_pool.sv
module tb_entropy_pool;

  localparam int          POOL = 64;
  localparam int          DIV  = 3;
  localparam logic [31:0] SEED = 32'h5EED_1234;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        irqUnderflow;
  logic        alertUnderflow;

  int          nTests = 0;
  int          nFail = 0;
  int          alertCount = 0;
  logic        lastAlert;
  logic [31:0] model = SEED;

  always #5 clk = ~clk;

  entropy_pool #(.POOL_BITS(POOL), .TICK_DIV(DIV), .SEED(SEED)) dut (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqUnderflow(irqUnderflow), .alertUnderflow(alertUnderflow)
  );

  always @(negedge clk) if (rstN && alertUnderflow) alertCount++;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic modelBit();
    model = {model[30:0], model[31] ^ model[21] ^ model[1] ^ model[0]};
    return model[0];
  endfunction

  function automatic logic [31:0] modelWord();
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) w = {w[30:0], modelBit()};
    return w;
  endfunction

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regReq = 1'b1; regWe = 1'b0; regAddr = a;
    @(negedge clk);
    d = regRdata;
    lastAlert = alertUnderflow;
    regReq = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regReq = 1'b1; regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regReq = 1'b0; regWe = 1'b0; regWdata = '0;
  endtask

  task automatic waitFull(output int polls);
    logic [31:0] c = '0;
    polls = 0;
    while (c != POOL && polls < 2000) begin
      regRead(2'd1, c);
      polls++;
    end
    check("R3", "pool reaches capacity", c, POOL);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int polls;
    int c0;
    int alertsBefore;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "irq after reset", 32'(irqUnderflow), 0);
    check("R1", "alert after reset", 32'(alertUnderflow), 0);
    regRead(2'd0, d); check("R1", "ctrl after reset", d, 0);
    regRead(2'd1, d); check("R1", "count after reset", d, 0);
    regRead(2'd3, d); check("R1", "status after reset", d, 0);

    // R8 nothing generated while disabled
    repeat (30) @(negedge clk);
    regRead(2'd1, d); check("R8", "count while disabled", d, 0);

    // R5/R6/R7 failed read on empty pool
    alertsBefore = alertCount;
    regRead(2'd2, d); check("R5", "failed read data", d, 0);
    check("R6", "alert after failed read", 32'(lastAlert), 1);
    regRead(2'd1, d); check("R5", "count after failed read", d, 0);
    check("R6", "single alert pulse", alertCount - alertsBefore, 1);
    regRead(2'd3, d); check("R7", "status flag set", d, 1);
    check("R7", "irq set", 32'(irqUnderflow), 1);
    regWrite(2'd3, 32'h0);
    regRead(2'd3, d); check("R7", "write 0 keeps flag", d, 1);
    regWrite(2'd3, 32'h1);
    regRead(2'd3, d); check("R7", "write 1 clears flag", d, 0);
    check("R7", "irq cleared", 32'(irqUnderflow), 0);

    // R9 writes to count and data ignored
    regWrite(2'd1, 32'hFFFF_FFFF);
    regWrite(2'd2, 32'hFFFF_FFFF);
    regRead(2'd1, d); check("R9", "count ignores writes", d, 0);

    // enable, immediate read must fail
    regWrite(2'd0, 32'h1);
    regRead(2'd0, d); check("R9", "ctrl readback", d, 1);
    regRead(2'd2, d); check("R5", "read right after enable", d, 0);
    check("R6", "alert right after enable", 32'(lastAlert), 1);
    regWrite(2'd3, 32'h1);

    // R2 fill cadence
    regRead(2'd1, d); c0 = int'(d);
    waitFull(polls);
    nTests++;
    if (polls < (POOL - c0) * DIV - 3 || polls > (POOL - c0) * DIV + 3) begin
      nFail++;
      $display("FAIL R2 fill time: actual %0d expected %0d", polls, (POOL - c0) * DIV);
    end

    // R3 stalled while full
    repeat (50) @(negedge clk);
    regRead(2'd1, d); check("R3", "count held at capacity", d, POOL);

    for (int r = 0; r < 16; r++) begin
      waitFull(polls);
      if (r % 4 == 3) begin
        regWrite(2'd0, 32'h0);
        for (int k = 0; k < POOL; k++) void'(modelBit());
        regRead(2'd1, d); check("R8", "flush empties pool", d, 0);
        regWrite(2'd0, 32'h1);
      end else begin
        regRead(2'd2, d); check("R4", "first word", d, modelWord());
        check("R6", "no alert on good read", 32'(lastAlert), 0);
        regRead(2'd1, d); check("R4", "count after one word", d, POOL - 32);
        regRead(2'd2, d); check("R4", "word at exactly 32 bits", d, modelWord());
        alertsBefore = alertCount;
        regRead(2'd2, d); check("R5", "read on drained pool", d, 0);
        check("R6", "alert on drained pool", 32'(lastAlert), 1);
        check("R7", "irq on drained pool", 32'(irqUnderflow), 1);
        @(negedge clk);
        check("R6", "alert is one pulse", alertCount - alertsBefore, 1);
        regWrite(2'd3, 32'h1);
        check("R7", "irq cleared in round", 32'(irqUnderflow), 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule